// File: doc/BRIEF.md
# SPI Octal Channel Controller

This block is a serial-port slave that controls eight low-side output channels. A host sends 16-bit command frames, most significant bit first. The frame holds a 2-bit mode for each channel. The four modes are standby, pass-through of a parallel input, forced on and forced off. From the mode, the block drives each channel's gate and its diagnostic-current enable. Driving a unipolar stepper motor or a set of relays then takes either a stream of command frames or the parallel inputs.

In every frame the block also returns a snapshot of the latched fault flags on its serial output. Each channel has an overload flag and an open-load flag. The snapshot is taken when chip select falls. Before the first serial clock edge, the serial output shows a transmission-error bit about the previous frame instead. That bit is also set by a single external mode-exit event input.

The serial pins are sampled by the system clock. The host's serial clock must therefore be slow enough that each level lasts at least two system clocks.

Top module: `octal_chan_ctrl`

## Requirements
- R1: After reset, every channel is in forced-off mode (command word all ones), all gates are 0 and all diagnostic enables are 0.
- R2: A frame is accepted at chip-select rise only if exactly 16 serial clock rises occurred while chip select was low. The bits are taken MSB first, and channel n (1..8) takes bits 2n-1:2n-2, so channel 8 uses bits 15:14.
- R3: A frame with any other count of clock rises leaves every channel's mode unchanged. It makes the error bit read 1 in the next frame. After an accepted frame with no other error event, the error bit reads 0.
- R4: Mode 00 (standby) drives gate 0 and diagnostic 0. It clears both fault flags of that channel and keeps them clear while the mode holds.
- R5: Mode 01 (pass-through) drives the gate equal to the channel's parallel input, and drives diagnostic as the inverse of that input.
- R6: Mode 10 (forced on) drives gate 1 and diagnostic 0.
- R7: Mode 11 (forced off) drives gate 0. Diagnostic is 0 until the first frame after reset is accepted, and 1 from then on.
- R8: A fault pulse sets a sticky flag that only standby or reset clears. In the returned word, the overload flag of channel n sits at bit 2(n-1) and its open-load flag at bit 2(n-1)+1. The word is captured when chip select falls, so pulses that arrive later appear only in the next frame.
- R9: From the fall of chip select until the first serial clock rise, the serial output shows the error bit. A pulse on the mode-exit input also makes the error bit read 1 in the next frame.
- R10: After the first serial clock rise, the serial output shows bit 15 of the snapshot. It advances one bit on each serial clock fall, so bit 15-k is valid while the clock is high after rise k+1.
- R11: While chip select is high, the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csb_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data in, sampled on serial clock rise |
| so_o | output | 1 | Serial data out |
| par_in_i | input | 8 | Parallel channel inputs for pass-through mode |
| ol_flt_i | input | 8 | Open-load fault pulses, one per channel |
| ov_flt_i | input | 8 | Overload/over-temperature fault pulses, one per channel |
| mode_exit_i | input | 1 | External mode-exit event, sets the error bit |
| gate_o | output | 8 | Channel gate drive, 1 = on |
| diag_o | output | 8 | Diagnostic-current enable per channel |

## Verification
If the command register is corrupted, the gates and diagnostic enables are wrong in the cycle after the frame closes. The first directed output check after any frame therefore catches it. A wrong error latch or a wrong frame counter shows only in the error bit of the following frame, one full transaction later. For that reason every bad-frame scenario is followed by two more frames. Wrong fault latching, wrong interleaving or a wrong snapshot time shows in the returned word of the next frame. The snapshot-timing case injects a pulse in the middle of a frame and reads two frames.

// File: rtl/octal_ctrl_pkg.sv
// Package: shared mode encoding for the octal channel controller.
// Assumes the 2-bit field layout of the command word.
package octal_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_STBY = 2'b00,
        MODE_PASS = 2'b01,
        MODE_ON   = 2'b10,
        MODE_OFF  = 2'b11
    } ch_mode_e;
endpackage

// File: rtl/oc_spi_frame.sv
// Serial frame engine. It shifts in command bits on serial clock rises,
// checks the frame length, commits the command word and shifts out the
// fault snapshot. It assumes the serial pins are synchronous to clk and
// that each serial level lasts at least two clk cycles.
module oc_spi_frame #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csb_i,
    input  logic                  sclk_i,
    input  logic                  si_i,
    input  logic [FRAME_BITS-1:0] snap_i,
    input  logic                  err_set_i,
    output logic                  so_o,
    output logic [FRAME_BITS-1:0] cmd_o,
    output logic                  commit_o
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

    logic                  csb_q, sclk_q;
    logic [CW-1:0]         cnt_q;
    logic [FRAME_BITS-1:0] rx_q, tx_q, cmd_q;
    logic                  started_q, ter_q, err_q;
    logic                  csb_fall, csb_rise, sck_rise, sck_fall, frame_ok;

    assign csb_fall = csb_q & ~csb_i;
    assign csb_rise = ~csb_q & csb_i;
    assign sck_rise = ~csb_i & sclk_i & ~sclk_q;
    assign sck_fall = ~csb_i & ~sclk_i & sclk_q;
    assign frame_ok = csb_rise && (cnt_q == CNT_FULL);

    // Pin history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csb_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csb_q  <= csb_i;
            sclk_q <= sclk_i;
        end
    end

    // Receive side: bit counter (saturating) and input shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= '0;
        end else if (csb_fall) begin
            cnt_q <= '0;
        end else if (sck_rise) begin
            rx_q  <= {rx_q[FRAME_BITS-2:0], si_i};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Command register: all ones at reset, loaded only by a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '1;
        else if (frame_ok) cmd_q <= rx_q;
    end

    // Error latch: set by a bad length or an external event, consumed at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (err_set_i || (csb_rise && !frame_ok)) err_q <= 1'b1;
        else if (csb_fall) err_q <= 1'b0;
    end

    // Transmit side: capture snapshot and error bit, shift on clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            started_q <= 1'b0;
            ter_q     <= 1'b0;
        end else if (csb_fall) begin
            tx_q      <= snap_i;
            started_q <= 1'b0;
            ter_q     <= err_q | err_set_i;
        end else if (sck_rise) begin
            started_q <= 1'b1;
        end else if (sck_fall && started_q) begin
            tx_q      <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign so_o     = csb_q ? 1'b0 : (started_q ? tx_q[FRAME_BITS-1] : ter_q);
    assign cmd_o    = cmd_q;
    assign commit_o = frame_ok;
endmodule

// File: rtl/oc_channel.sv
// One output channel. It decodes its 2-bit mode into gate and diagnostic
// drive and keeps sticky fault flags. It assumes fault inputs are pulses
// synchronous to clk. diag_ok_i is low until the first frame is accepted.
module oc_channel
    import octal_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       par_in_i,
    input  logic       ol_p_i,
    input  logic       ov_p_i,
    input  logic       diag_ok_i,
    output logic       gate_o,
    output logic       diag_o,
    output logic       ol_o,
    output logic       ov_o
);
    ch_mode_e mode;
    assign mode = ch_mode_e'(mode_i);

    // Output decode per mode.
    always_comb begin
        unique case (mode)
            MODE_STBY: begin gate_o = 1'b0;     diag_o = 1'b0;      end
            MODE_PASS: begin gate_o = par_in_i; diag_o = ~par_in_i; end
            MODE_ON:   begin gate_o = 1'b1;     diag_o = 1'b0;      end
            default:   begin gate_o = 1'b0;     diag_o = diag_ok_i; end
        endcase
    end

    // Sticky fault flags, cleared and held clear in standby.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_STBY) begin
            ol_o <= 1'b0;
            ov_o <= 1'b0;
        end else begin
            ol_o <= ol_o | ol_p_i;
            ov_o <= ov_o | ov_p_i;
        end
    end
endmodule

// File: rtl/octal_chan_ctrl.sv
// Top of the octal channel controller: the serial frame engine plus one
// channel slice per output. It assumes all inputs are synchronous to clk.
module octal_chan_ctrl #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           csb_i,
    input  logic           sclk_i,
    input  logic           si_i,
    output logic           so_o,
    input  logic [NCH-1:0] par_in_i,
    input  logic [NCH-1:0] ol_flt_i,
    input  logic [NCH-1:0] ov_flt_i,
    input  logic           mode_exit_i,
    output logic [NCH-1:0] gate_o,
    output logic [NCH-1:0] diag_o
);
    localparam int FB = 2 * NCH;

    logic [FB-1:0]  cmd, snap;
    logic [NCH-1:0] flt_ol, flt_ov;
    logic           commit, por_q;

    // Power-on marker: cleared by the first accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) por_q <= 1'b1;
        else if (commit) por_q <= 1'b0;
    end

    oc_spi_frame #(.FRAME_BITS(FB)) u_frame (
        .clk(clk), .rst_n(rst_n), .csb_i(csb_i), .sclk_i(sclk_i), .si_i(si_i),
        .snap_i(snap), .err_set_i(mode_exit_i), .so_o(so_o),
        .cmd_o(cmd), .commit_o(commit)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        oc_channel u_ch (
            .clk(clk), .rst_n(rst_n), .mode_i(cmd[2*n+1:2*n]),
            .par_in_i(par_in_i[n]), .ol_p_i(ol_flt_i[n]), .ov_p_i(ov_flt_i[n]),
            .diag_ok_i(~por_q), .gate_o(gate_o[n]), .diag_o(diag_o[n]),
            .ol_o(flt_ol[n]), .ov_o(flt_ov[n])
        );
        assign snap[2*n]   = flt_ov[n];
        assign snap[2*n+1] = flt_ol[n];
    end
endmodule

// File: rtl/oc_chk.sv
// Checker for octal_chan_ctrl. It keeps its own pin history, clock-rise
// count and receive shifter, and relates them to the command word, the
// fault flags and the outputs.
module oc_chk #(
    parameter int NCH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csb_i,
    input logic            sclk_i,
    input logic            si_i,
    input logic            so_o,
    input logic [NCH-1:0]  gate_o,
    input logic [NCH-1:0]  diag_o,
    input logic [2*NCH-1:0] cmd,
    input logic [NCH-1:0]  flt_ol,
    input logic [NCH-1:0]  flt_ov
);
    localparam int FB = 2 * NCH;

    logic          c_csb_q, c_sclk_q;
    int unsigned   c_cnt;
    logic [FB-1:0] c_rx;
    logic [NCH-1:0] stby, on_m;
    logic          c_rise;

    for (genvar n = 0; n < NCH; n++) begin : g_m
        assign stby[n] = (cmd[2*n+1:2*n] == 2'b00);
        assign on_m[n] = (cmd[2*n+1:2*n] == 2'b10);
    end
    assign c_rise = ~c_csb_q & csb_i;

    // Independent frame tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_csb_q <= 1'b1; c_sclk_q <= 1'b0; c_cnt <= 0; c_rx <= '0;
        end else begin
            c_csb_q  <= csb_i;
            c_sclk_q <= sclk_i;
            if (c_csb_q && !csb_i) c_cnt <= 0;
            else if (!csb_i && sclk_i && !c_sclk_q) begin
                c_cnt <= (c_cnt < 1000) ? c_cnt + 1 : c_cnt;
                c_rx  <= {c_rx[FB-2:0], si_i};
            end
        end
    end

    p_full_frame_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rise && c_cnt == FB) |=> (cmd == $past(c_rx)));
    p_bad_frame_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rise && c_cnt != FB) |=> $stable(cmd));
    p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_o & stby) == '0) && ((diag_o & stby) == '0));
    p_standby_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stby != '0) |=> (((flt_ol | flt_ov) & $past(stby)) == '0));
    p_gate_diag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o & diag_o) == '0);
    p_forced_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_o & on_m) == on_m) && ((diag_o & on_m) == '0));
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flt_ol | flt_ov) != '0) |=>
        (((flt_ol & ~$past(stby)) & $past(flt_ol)) == ($past(flt_ol) & ~$past(stby))));
    p_so_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        c_csb_q |-> !so_o);
endmodule

bind octal_chan_ctrl oc_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_octal_chan_ctrl.sv
module sim_octal_chan_ctrl;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       csb = 1'b1, sclk = 1'b0, si = 1'b0, mexit = 1'b0;
    logic [7:0] pin = '0, ol = '0, ov = '0;
    logic       so;
    logic [7:0] gate, diag;
    int         n_run = 0, n_fail = 0;
    bit         diag_armed = 0;

    always #10 clk = ~clk;  // 50 MHz

    octal_chan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .csb_i(csb), .sclk_i(sclk), .si_i(si), .so_o(so),
        .par_in_i(pin), .ol_flt_i(ol), .ov_flt_i(ov), .mode_exit_i(mexit),
        .gate_o(gate), .diag_o(diag)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outputs from the mode rules (R5, R6, R7, R4).
    task automatic check_outputs(input logic [15:0] w, input string req);
        logic [7:0] eg, ed;
        for (int n = 0; n < 8; n++) begin
            case (w[2*n +: 2])
                2'b00: begin eg[n] = 0;      ed[n] = 0;       end
                2'b01: begin eg[n] = pin[n]; ed[n] = ~pin[n]; end
                2'b10: begin eg[n] = 1;      ed[n] = 0;       end
                default: begin eg[n] = 0;    ed[n] = diag_armed; end
            endcase
        end
        chk(gate == eg, {req, " gate"}, {8'h0, gate}, {8'h0, eg});
        chk(diag == ed, {req, " diag"}, {8'h0, diag}, {8'h0, ed});
    endtask

    task automatic spi_begin(output logic ter);
        csb = 1'b0; tick(3); ter = so;
    endtask

    task automatic spi_bits(input logic [15:0] tx, input int nclk, output logic [15:0] rx);
        rx = '0;
        for (int i = 0; i < nclk; i++) begin
            si = (i < 16) ? tx[15-i] : 1'b0;
            tick(2); sclk = 1'b1; tick(2);
            if (i < 16) rx[15-i] = so;
            sclk = 1'b0; tick(2);
        end
    endtask

    task automatic spi_end();
        csb = 1'b1; tick(3);
    endtask

    task automatic xfer(input logic [15:0] tx, input int nclk, output logic ter, output logic [15:0] rx);
        spi_begin(ter); spi_bits(tx, nclk, rx); spi_end();
        if (nclk == 16) diag_armed = 1;
    endtask

    task automatic t_reset();
        chk(gate == 8'h00, "R1 gate", {8'h0, gate}, 16'h0);
        chk(diag == 8'h00, "R1/R7 diag before first frame", {8'h0, diag}, 16'h0);
        chk(so == 1'b0, "R11 so idle", {15'h0, so}, 16'h0);
    endtask

    task automatic t_forced_on();
        logic t; logic [15:0] r;
        xfer(16'hAAAA, 16, t, r);
        chk(t == 1'b0, "R9 ter clean after reset", {15'h0, t}, 16'h0);
        check_outputs(16'hAAAA, "R6");
    endtask

    task automatic t_mixed();
        logic t; logic [15:0] r;
        xfer(16'hE41B, 16, t, r);
        pin = 8'h00; tick(1); check_outputs(16'hE41B, "R2/R5/R7 in=00");
        pin = 8'hFF; tick(1); check_outputs(16'hE41B, "R2/R5/R7 in=FF");
        pin = 8'h24; tick(1); check_outputs(16'hE41B, "R5 in=24");
        chk(gate[2] == 1'b1 && diag[2] == 1'b0, "R5 ch3 follows", {14'h0, gate[2], diag[2]}, 16'h2);
        chk(gate[3] == 1'b0 && diag[3] == 1'b0, "R4 ch4 standby", {14'h0, gate[3], diag[3]}, 16'h0);
    endtask

    task automatic t_bad_frames();
        logic t; logic [15:0] r;
        xfer(16'h5555, 15, t, r);
        check_outputs(16'hE41B, "R3 short frame ignored");
        xfer(16'h5555, 17, t, r);
        chk(t == 1'b1, "R3 ter after short frame", {15'h0, t}, 16'h1);
        check_outputs(16'hE41B, "R3 long frame ignored");
        xfer(16'hFFFF, 16, t, r);
        chk(t == 1'b1, "R3 ter after long frame", {15'h0, t}, 16'h1);
        xfer(16'hFFFF, 16, t, r);
        chk(t == 1'b0, "R3 ter cleared after good frame", {15'h0, t}, 16'h0);
        check_outputs(16'hFFFF, "R7 forced off armed");
    endtask

    task automatic t_faults();
        logic t; logic [15:0] r;
        ov = 8'h04; ol = 8'h80; tick(1); ov = '0; ol = '0; tick(2);
        chk(so == 1'b0, "R11 so idle with faults", {15'h0, so}, 16'h0);
        xfer(16'hFFFF, 16, t, r);
        chk(r == 16'h8010, "R8/R10 fault word", r, 16'h8010);
        xfer(16'hFFCF, 16, t, r);
        chk(r == 16'h8010, "R8 sticky", r, 16'h8010);
        ov = 8'h04; tick(1); ov = '0; tick(1);
        xfer(16'hFFFF, 16, t, r);
        chk(r == 16'h8000, "R4 standby cleared ch3", r, 16'h8000);
        spi_begin(t);
        ov = 8'h01; ol = 8'h02; tick(1); ov = '0; ol = '0;
        spi_bits(16'hFFFF, 16, r); spi_end();
        chk(r == 16'h8000, "R8 snapshot at csb fall", r, 16'h8000);
        xfer(16'hFFFF, 16, t, r);
        chk(r == 16'h8009, "R8 late pulses next frame", r, 16'h8009);
    endtask

    task automatic t_mode_exit();
        logic t; logic [15:0] r;
        mexit = 1'b1; tick(1); mexit = 1'b0; tick(2);
        xfer(16'hFFFF, 16, t, r);
        chk(t == 1'b1, "R9 mode exit sets ter", {15'h0, t}, 16'h1);
        xfer(16'hFFFF, 16, t, r);
        chk(t == 1'b0, "R9 ter consumed", {15'h0, t}, 16'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(4); rst_n = 1'b1; tick(2);
        t_reset();
        t_forced_on();
        t_mixed();
        t_bad_frames();
        t_faults();
        t_mode_exit();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule